// File: doc/BRIEF.md
# Two-Multiplier Time-Shared FIR Filter

This block is a four-tap integer filter whose arithmetic is done by only two single-cycle combinational multipliers. The multipliers are reused over a fixed two-phase schedule. In the fetch phase, multiplier lane 0 forms x*2 and lane 1 forms y*3 while the filter waits for the next sample on a valid/ready input stream. In the following sum phase, lane 0 forms x*7 and lane 1 forms y*9, and the four products are added into a registered result. The result is then offered on a valid/ready output stream. Here x is the oldest sample in the window and y the one after it.

The sample window is (x, y, z, w), where w is the newest sample. When a result is taken, the window moves one place: it becomes (y, z, w, s), where s is the sample fetched during that round. Each tap is always served by the same multiplier lane. The phases follow each other in a strict order, so no two callers ever compete for a multiplier and no arbitration logic is present. Samples are 16-bit two's complement values, and the result is a 24-bit two's complement value.

Top module: `fir2x_tshare`

## Requirements
- R1: After a synchronous active-high reset, in_ready is 1, out_valid is 0 and all four window samples are zero. The first result after reset is therefore 0, whatever sample is fetched with it.
- R2: While the block waits for a sample and in_valid is 0, in_ready stays 1 and out_valid stays 0.
- R3: A sample accepted at a clock edge (in_valid and in_ready both 1) is followed by one cycle in which in_ready and out_valid are both 0. out_valid is 1 after the second edge.
- R4: The result equals 2*x + 3*y + 7*x + 9*y = 9*x + 12*y, computed from the window as it stood before the sample of that round is shifted in. The result is a 24-bit signed value on out_data.
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.
- R6: A result taken at an edge (out_valid and out_ready both 1) shifts the window to (y, z, w, fetched sample). in_ready is 1 after that edge.
- R7: in_ready and out_valid are never both 1.
- R8: Extreme samples (-32768 and 32767) give exact results, with no wrap-around in the 24-bit sum.
- R9: A sample presented while in_ready is 0 is not taken. Later results match a window that never saw it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Filter is in the fetch phase and will take a sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 24 | Signed filter result |

## Verification
A sample taken at edge k leaves both handshake outputs low for the one cycle after k, which is the sum phase. The result appears after edge k+1. The bench drives every input at the falling edge and samples the ports one falling edge after each edge it reasons about. It therefore checks the quiet sum cycle first, then the result, then each held cycle, and after the output handshake it checks that in_ready has returned. The expected results come from a four-entry sample model in the bench, which applies 9*x + 12*y and shifts only on taken results. This is done over extreme values and a long pseudo-random sample run with varied stalls, holds and ignored input strobes.

// File: rtl/fir2x_pkg.sv
package fir2x_pkg;

    localparam int SAMPLE_W_DEF = 16;
    localparam int SUM_W_DEF    = 24;
    localparam int COEF_W       = 5;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_SUM   = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

    typedef struct packed {
        logic take_in;
        logic take_out;
        logic late;
    } step_s;

    // Fixed pairing: lane 0 serves the oldest tap, lane 1 the next one.
    function automatic logic signed [COEF_W-1:0] coef_of(input int lane, input logic late);
        logic signed [COEF_W-1:0] c;
        if (lane == 0) c = late ? 5'sd7 : 5'sd2;
        else           c = late ? 5'sd9 : 5'sd3;
        return c;
    endfunction

endpackage

// File: rtl/fir2x_mul.sv
module fir2x_mul #(
    parameter int IN_W  = 16,
    parameter int CF_W  = 5,
    parameter int OUT_W = 24
) (
    input  logic signed [IN_W-1:0]  a,
    input  logic signed [CF_W-1:0]  c,
    output logic signed [OUT_W-1:0] p
);
    logic signed [OUT_W-1:0] a_ext;
    logic signed [OUT_W-1:0] c_ext;

    assign a_ext = OUT_W'(a);
    assign c_ext = OUT_W'(c);
    assign p     = a_ext * c_ext;
endmodule

// File: rtl/fir2x_window.sv
module fir2x_window #(
    parameter int W     = 16,
    parameter int TAPS  = 4,
    parameter int LANES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift,
    input  logic signed [W-1:0]        din,
    output logic signed [W-1:0]        lead [LANES]
);
    logic signed [W-1:0] tap [TAPS];

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        if (i == TAPS - 1) begin : g_last
            always_ff @(posedge clk) begin
                if (rst)        tap[i] <= '0;
                else if (shift) tap[i] <= din;
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst)        tap[i] <= '0;
                else if (shift) tap[i] <= tap[i+1];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lead
        assign lead[l] = tap[l];
    end
endmodule

// File: rtl/fir2x_seq.sv
module fir2x_seq
    import fir2x_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_valid,
    input  logic   out_ready,
    output phase_e ph,
    output step_s  st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= PH_FETCH;
        end else begin
            unique case (ph)
                PH_FETCH: if (in_valid)  ph <= PH_SUM;
                PH_SUM:                  ph <= PH_HOLD;
                PH_HOLD:  if (out_ready) ph <= PH_FETCH;
                default:                 ph <= PH_FETCH;
            endcase
        end
    end

    always_comb begin
        st.take_in  = (ph == PH_FETCH) && in_valid;
        st.take_out = (ph == PH_HOLD) && out_ready;
        st.late     = (ph == PH_SUM);
    end
endmodule

// File: rtl/fir2x_tshare.sv
module fir2x_tshare
    import fir2x_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int SUM_W    = SUM_W_DEF,
    parameter int TAPS     = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SUM_W-1:0]    out_data
);
    localparam int LANES = 2;

    phase_e ph;
    step_s  st;

    logic signed [SAMPLE_W-1:0] lead [LANES];
    logic signed [SAMPLE_W-1:0] fetched;
    logic signed [SUM_W-1:0]    prod [LANES];
    logic signed [SUM_W-1:0]    early [LANES];
    logic signed [SUM_W-1:0]    total;
    logic signed [SUM_W-1:0]    result;

    fir2x_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .ph        (ph),
        .st        (st)
    );

    fir2x_window #(.W(SAMPLE_W), .TAPS(TAPS), .LANES(LANES)) u_win (
        .clk   (clk),
        .rst   (rst),
        .shift (st.take_out),
        .din   (fetched),
        .lead  (lead)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fir2x_mul #(.IN_W(SAMPLE_W), .CF_W(COEF_W), .OUT_W(SUM_W)) u_mul (
            .a (lead[l]),
            .c (coef_of(l, st.late)),
            .p (prod[l])
        );

        always_ff @(posedge clk) begin
            if (rst)             early[l] <= '0;
            else if (st.take_in) early[l] <= prod[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             fetched <= '0;
        else if (st.take_in) fetched <= $signed(in_data);
    end

    always_comb begin
        total = '0;
        for (int l = 0; l < LANES; l++) begin
            total = total + early[l] + prod[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          result <= '0;
        else if (st.late) result <= total;
    end

    assign in_ready  = (ph == PH_FETCH);
    assign out_valid = (ph == PH_HOLD);
    assign out_data  = result;
endmodule

// File: rtl/fir2x_check.sv
module fir2x_check #(
    parameter int SUM_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [SUM_W-1:0] out_data
);
    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    assert_idle_wait_R2: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (in_ready && !out_valid));

    assert_sum_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!in_ready && !out_valid));

    assert_result_due_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> ##2 out_valid);

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_return_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    assert_no_early_out_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(!in_ready && !out_valid));
endmodule

bind fir2x_tshare fir2x_check #(.SUM_W(SUM_W)) u_fir2x_check (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/test_fir2x_tshare.sv
`timescale 1ns/1ps
module test_fir2x_tshare;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model of the window: m[0] oldest (x), m[3] newest (w)
    int m [4];

    always #2.5 clk = ~clk;

    fir2x_tshare i_fir2x_tshare (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) m[i] = 0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    endtask

    // One full round: optional stall, sample fetch, result check, hold, take.
    task automatic round(input int sample, input int stall, input int hold,
                         input bit junk, input string req);
        int exp;
        int held;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(in_ready == 1'b1 && out_valid == 1'b0, "R2 stall",
                int'({in_ready, out_valid}), 2);
        end
        in_valid = 1'b1;
        in_data  = 16'(sample);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        // sum phase cycle
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R3 gap",
            int'({in_ready, out_valid}), 0);
        if (junk) begin
            in_valid = 1'b1;
            in_data  = ~16'(sample);
        end
        exp = 9 * m[0] + 12 * m[1];
        @(negedge clk);
        chk(out_valid == 1'b1, "R3 due", int'(out_valid), 1);
        chk($signed(out_data) == exp, req, int'($signed(out_data)), exp);
        held = int'($signed(out_data));
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b1 && int'($signed(out_data)) == held, "R5 hold",
                int'($signed(out_data)), held);
            chk(in_ready == 1'b0, "R9 not ready", int'(in_ready), 0);
        end
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R6 back to fetch",
            int'({in_ready, out_valid}), 2);
        m[0] = m[1];
        m[1] = m[2];
        m[2] = m[3];
        m[3] = sample;
    endtask

    initial begin
        int ext [8];
        logic [15:0] lfsr;
        ext = '{32767, -32768, 32767, 32767, -32768, -32768, -1, 1};
        do_reset();
        // R1: first result after reset comes from the cleared window
        round(12345, 0, 0, 1'b0, "R1 first result");
        // R8: extremes, every pairing of max and min reaches x and y
        foreach (ext[i]) round(ext[i], i % 2, 1, 1'b0, "R8 extreme");
        // R4 / R9: long pseudo-random sweep with stalls, holds, ignored strobes
        lfsr = 16'hACE1;
        for (int n = 0; n < 160; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            round(int'($signed(lfsr)), n % 3, (n / 3) % 4, n[0],
                  n[0] ? "R9 ignored strobe" : "R4 result");
        end
        // R1 again: reset in the middle of a run clears the window
        do_reset();
        round(-777, 2, 0, 1'b0, "R1 after mid reset");
        round(-777, 0, 2, 1'b1, "R4 after mid reset");
        round(500, 1, 0, 1'b0, "R4 after mid reset");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule